// File: doc/BRIEF.md
# Write-Protected Watchdog Timer

The block is a watchdog for a small CPU. A free-running counter advances on a tick taken from one of two pre-divided oscillator strobes. If software fails to restart it before it wraps, the block raises a non-maskable interrupt request. Software talks to the block through one 8-bit control register on a plain write/read port.

The interrupt enable and the tick-source select are guarded. Software first writes the unlock bit. Exactly one following write may then commit new values, after which the guard closes again by itself. Clearing the interrupt enable only masks the request. The counter keeps running, so software restarts it before it enables the request again. A restart needs no unlock.

Top module: `guarded_watchdog`

## Requirements
- R1: After reset the register reads 0x40: unlock bit 7 = 0, enable bit 6 = 1, select bit 5 = 0. The counter is zero and `nmi_req_o` is low.
- R2: `rd_data_o` shows unlock at bit 7, enable at bit 6 and select at bit 5. Bits 4 to 0 always read 0, including the restart bit 0.
- R3: While unlock is 0, a write never changes enable or select. The write only loads bit 7 into unlock. Enable or select values carried in the same write as a 0-to-1 unlock are dropped.
- R4: While unlock is 1, a write with bit 7 = 1 loads enable from bit 6 and select from bit 5, and clears unlock. The new values are visible the cycle after the write.
- R5: While unlock is 1, a write with bit 7 = 0 clears unlock and leaves enable and select unchanged.
- R6: Any write with bit 0 = 1 clears the counter and the overflow state, whatever the unlock state. A write with bit 0 = 0 leaves the counter alone.
- R7: With select = 0 the counter advances only on `slow_tick_i`. With select = 1 it advances only on `fast_tick_i`. The other strobe is ignored.
- R8: The counter is CNT_W bits wide and advances by one on each selected tick. The tick that wraps it from all ones to zero records an overflow. With enable = 1, `nmi_req_o` goes high the cycle after the 2^CNT_W-th tick following a restart.
- R9: `nmi_req_o` is a level that equals overflow AND enable. It stays high until a restart or until enable is cleared. While enable = 0 the counter and overflow still advance, so enabling again without a restart raises the request at once.
- R10: When a restart write and a selected tick fall in the same cycle, the restart wins and the counter reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| slow_tick_i | input | 1 | Count strobe from the slow oscillator divided by 16 |
| fast_tick_i | input | 1 | Count strobe from the fast oscillator divided by 16 |
| nmi_req_o | output | 1 | Non-maskable interrupt request level |

## Verification
The assertions assume that the tick strobes and the write strobe are synchronous one-cycle-wide enables sampled on the rising clock. They also assume that each cycle holding `wr_en_i` high is exactly one register write. The bench drives every input on the falling edge, holds each strobe for whole cycles only, and never leaves a write strobe high beyond its cycle. With a 4-bit counter the bench can sweep all 256 write values against the locked register. It can also count ticks across the wrap for both tick sources, so every expected value is plain arithmetic on the tick count since the last restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned UNLK_POS = 7;
  localparam int unsigned ENA_POS  = 6;
  localparam int unsigned SEL_POS  = 5;
  localparam int unsigned RST_POS  = 0;

  typedef struct packed {
    logic unlock;
    logic ena;
    logic sel;
  } wdt_ctrl_t;

  localparam wdt_ctrl_t CTRL_RESET = '{unlock: 1'b0, ena: 1'b1, sel: 1'b0};
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output wdt_ctrl_t        ctrl_o,
  output logic             restart_o,
  output logic [REG_W-1:0] rd_data_o
);
  wdt_ctrl_t ctrl_q;
  logic      unused_bits;

  assign unused_bits = ^wr_data_i[SEL_POS-1:RST_POS+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en_i) begin
      if (!ctrl_q.unlock) begin
        // locked: only the guard bit may move
        ctrl_q.unlock <= wr_data_i[UNLK_POS];
      end else begin
        ctrl_q.unlock <= 1'b0;
        if (wr_data_i[UNLK_POS]) begin
          ctrl_q.ena <= wr_data_i[ENA_POS];
          ctrl_q.sel <= wr_data_i[SEL_POS];
        end
      end
    end
  end

  assign restart_o = wr_en_i & wr_data_i[RST_POS];
  assign ctrl_o    = ctrl_q;

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[UNLK_POS] = ctrl_q.unlock;
    rd_data_o[ENA_POS]  = ctrl_q.ena;
    rd_data_o[SEL_POS]  = ctrl_q.sel;
  end
endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux #(
  parameter int unsigned NUM_SRC = 2,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/guarded_watchdog.sv
module guarded_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             slow_tick_i,
  input  logic             fast_tick_i,
  output logic             nmi_req_o
);
  wdt_ctrl_t        ctrl;
  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             unlock_st;
  logic             ena_st;
  logic             sel_st;

  wdt_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .restart_o (restart),
    .rd_data_o (rd_data_o)
  );

  assign unlock_st = ctrl.unlock;
  assign ena_st    = ctrl.ena;
  assign sel_st    = ctrl.sel;

  wdt_tick_mux #(.NUM_SRC(2)) u_mux (
    .tick_i ({fast_tick_i, slow_tick_i}),
    .sel_i  (sel_st),
    .tick_o (tick)
  );

  wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (restart),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  // masking gates only the request, never the count
  assign nmi_req_o = ovf & ena_st;
endmodule

// File: rtl/guarded_watchdog_chk.sv
module guarded_watchdog_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       rd_data_o,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             unlock_st,
  input logic             ena_st,
  input logic             sel_st,
  input logic             nmi_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !unlock_st |=> $stable(ena_st) && $stable(sel_st)
                              && (unlock_st == $past(wr_data_i[7])));

  a_r4_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && unlock_st && wr_data_i[7] |=> !unlock_st
      && (ena_st == $past(wr_data_i[6])) && (sel_st == $past(wr_data_i[5])));

  a_r5_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && unlock_st && !wr_data_i[7] |=> !unlock_st && $stable(ena_st) && $stable(sel_st));

  a_r2_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_data_i[4:0] != 5'd0) |=> rd_data_o[4:0] == 5'd0);

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[0] |=> (cnt == '0) && !ovf && !nmi_req_o);

  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !(wr_en_i && wr_data_i[0]) |=> cnt == $past(cnt) + 1'b1);

  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !(wr_en_i && wr_data_i[0]) |=> $stable(cnt) && $stable(ovf));

  a_r9_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_req_o) |-> $past(tick && cnt == CNT_MAX) || $rose(ena_st));
endmodule

bind guarded_watchdog guarded_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .tick      (tick),
  .cnt       (cnt),
  .ovf       (ovf),
  .unlock_st (unlock_st),
  .ena_st    (ena_st),
  .sel_st    (sel_st),
  .nmi_req_o (nmi_req_o)
);

// File: tb/guarded_watchdog_test.sv
module guarded_watchdog_test;
  localparam int unsigned W    = 4;
  localparam int          WRAP = 1 << W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       slow_tick = 1'b0;
  logic       fast_tick = 1'b0;
  logic       nmi;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  guarded_watchdog #(.CNT_W(W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .slow_tick_i (slow_tick),
    .fast_tick_i (fast_tick),
    .nmi_req_o   (nmi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [7:0] d, input logic with_tick = 1'b0);
    wr_en = 1'b1;
    wr_data = d;
    slow_tick = with_tick;
    fast_tick = with_tick;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    slow_tick = 1'b0;
    fast_tick = 1'b0;
  endtask

  task automatic ticks(input logic fast, input int n);
    if (n > 0) begin
      if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      fast_tick = 1'b0;
      slow_tick = 1'b0;
    end
  endtask

  task automatic set_ctrl(input logic e, input logic s);
    wr(8'h80);
    wr({1'b1, e, s, 5'b0});
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 read during reset", {24'd0, rd_data}, 32'h40);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset read", {24'd0, rd_data}, 32'h40);
    chk("R1 reset nmi", {31'd0, nmi}, 32'd0);
    ticks(1'b0, WRAP - 1);
    chk("R1 counter from zero", {31'd0, nmi}, 32'd0);
    ticks(1'b0, 1);
    chk("R1 counter from zero wrap", {31'd0, nmi}, 32'd1);
    wr(8'h01);

    // R3/R2: every value against the locked register
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      wr(dv);
      chk("R3 R2 locked write", {24'd0, rd_data}, {24'd0, dv[7], 7'h40});
      if (dv[7]) begin
        wr(8'h00);
        chk("R5 cancel after locked sweep", {24'd0, rd_data}, 32'h40);
      end
    end

    // R4/R5: commit and cancel for each enable/select pair
    for (int k = 0; k < 4; k++) begin
      logic e, s;
      e = k[1];
      s = k[0];
      wr(8'h80);
      chk("R4 unlocked read", {24'd0, rd_data}, {24'd0, 1'b1, 1'b1, 1'b0, 5'd0});
      wr({1'b1, e, s, 5'b0});
      chk("R4 commit", {24'd0, rd_data}, {24'd0, 1'b0, e, s, 5'd0});
      wr({1'b0, 1'b1, 1'b0, 5'b0});
      chk("R3 guard closed after commit", {24'd0, rd_data}, {24'd0, 1'b0, e, s, 5'd0});
      wr(8'h80);
      wr({1'b0, ~e, ~s, 5'b0});
      chk("R5 cancel keeps values", {24'd0, rd_data}, {24'd0, 1'b0, e, s, 5'd0});
      set_ctrl(1'b1, 1'b0);
    end

    // R7/R8: tick count sweep for both sources
    for (int s = 0; s < 2; s++) begin
      set_ctrl(1'b1, s[0]);
      for (int n = 0; n <= WRAP + 2; n++) begin
        wr(8'h01);
        ticks(s[0], n);
        chk("R8 overflow after 2^W ticks", {31'd0, nmi}, {31'd0, n >= WRAP});
      end
      wr(8'h01);
      ticks(~s[0], 3 * WRAP);
      chk("R7 other source ignored", {31'd0, nmi}, 32'd0);
      ticks(s[0], WRAP);
      chk("R7 selected source counts", {31'd0, nmi}, 32'd1);
    end
    set_ctrl(1'b1, 1'b0);

    // R6: restart while locked, write of bit0=0 harmless
    wr(8'h01);
    ticks(1'b0, 10);
    wr(8'h00);
    ticks(1'b0, WRAP - 10);
    chk("R6 zero restart bit no effect", {31'd0, nmi}, 32'd1);
    wr(8'h01);
    chk("R6 restart clears request", {31'd0, nmi}, 32'd0);
    ticks(1'b0, WRAP - 1);
    chk("R6 count restarted from zero", {31'd0, nmi}, 32'd0);

    // R9: masking, level hold, re-enable
    wr(8'h01);
    ticks(1'b0, WRAP);
    repeat (5) @(negedge clk);
    chk("R9 level held", {31'd0, nmi}, 32'd1);
    set_ctrl(1'b0, 1'b0);
    chk("R9 mask drops request", {31'd0, nmi}, 32'd0);
    set_ctrl(1'b1, 1'b0);
    chk("R9 re-enable without restart", {31'd0, nmi}, 32'd1);
    wr(8'h01);
    set_ctrl(1'b0, 1'b0);
    ticks(1'b0, WRAP);
    chk("R9 masked overflow silent", {31'd0, nmi}, 32'd0);
    set_ctrl(1'b1, 1'b0);
    chk("R9 count ran while masked", {31'd0, nmi}, 32'd1);

    // R10: restart beats a tick in the same cycle
    wr(8'h01, 1'b1);
    ticks(1'b0, WRAP - 1);
    chk("R10 restart wins over tick", {31'd0, nmi}, 32'd0);
    ticks(1'b0, 1);
    chk("R10 wrap after full count", {31'd0, nmi}, 32'd1);

    finish_up();
  end
endmodule